// File: doc/BRIEF.md
# Double-Buffered Segmented DAC Register

This block is the digital front end of a 14-bit parallel-load current-steering converter. A host drives a 14-bit data word together with three active-low strobes: chip select, write and load. Two registers sit in series behind them. The first is an input register that holds a word that has been written. The second is a DAC register that holds the code the converter is producing. Because the load strobe works independently of chip select, several such blocks can each be written in turn. One shared load strobe then moves every staged word to its output in the same cycle.

The strobes and the data word pass together through a two-flop synchronizer into the system clock domain, so the strobe and the data stay aligned. A small state machine qualifies the write. The selected write (chip select and write both low) must be seen for at least `MIN_WR` clocks before it counts as a capture. A shorter pulse is discarded and sets a sticky error flag. The state machine has three states:
- `ST_IDLE`: no write selected.
- `ST_ARM`: a write is selected but has not yet been held long enough.
- `ST_OPEN`: the write is qualified.

Its transitions are:
- IDLE→ARM on a new select.
- IDLE→OPEN or ARM→OPEN when the hold count is reached.
- ARM→IDLE when the select drops early, which raises the error.
- OPEN→IDLE when the select drops.

The DAC register code is split for the switch network. The upper three bits become a 7-segment thermometer vector of equally weighted switches. The lower eleven bits drive the binary ladder directly.

Top module: `seg_dac_front`

## Requirements
- R1: A synchronous active-high reset clears both registers, so `dac_code`, `therm_en` and `ladder_en` are all zero, and it clears `short_err`.
- R2: While chip select and write are low and load is high for at least `MIN_WR` clocks, the input register takes the bus value and `dac_code` does not change.
- R3: While load is low and the write is not qualified (chip select or write high), the DAC register copies the input register.
- R4: While chip select, write and load are all low and the write is qualified, both registers take the bus value, so `dac_code` follows the bus.
- R5: While load is high and no qualified write is present, neither register changes, whatever the bus does.
- R6: If load stays low after write is released, the DAC register ends holding the last word captured before the release. A bus value that is present only after the release is not captured.
- R7: `therm_en[i]` is 1 exactly when `dac_code[13:11]` is greater than i (i = 0..6), so code k sets the k lowest bits.
- R8: `ladder_en` equals `dac_code[10:0]` bit for bit, with bit 0 the least significant.
- R9: A selected write held for fewer than `MIN_WR` clocks changes neither register. It sets `short_err`, which then stays 1 until reset.
- R10: A change on the strobes appears at `dac_code` on the third rising clock edge after it, two edges for synchronization and one for the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe to the DAC register, active low |
| data_in | input | 14 | Parallel data word, bit 13 most significant |
| therm_en | output | 7 | Thermometer switch enables from the upper 3 code bits |
| ladder_en | output | 11 | Binary ladder switch enables, the lower 11 code bits |
| dac_code | output | 14 | Current DAC register contents |
| short_err | output | 1 | Sticky flag for a write pulse shorter than `MIN_WR` clocks |

## Verification
A qualified capture and a DAC load can fall in the same clock when all three strobes are held low together. The bench provokes this with directed transparent writes over every value of the upper three bits, and with random transparent operations. It judges that `dac_code` equals the bus word itself rather than the older staged word. A second overlap comes from releasing write while load stays low and a new word sits on the bus. That case is judged by `dac_code` holding the last word captured before the release.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_OPEN = 2'd2
    } wr_state_t;
endpackage

// File: rtl/dual_ff_sync.sv
module dual_ff_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/wr_qualifier.sv
module wr_qualifier
    import seg_dac_pkg::*;
#(
    parameter int MIN_WR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic wr_ok,
    output logic short_err
);
    localparam int            CW  = (MIN_WR > 1) ? $clog2(MIN_WR) : 1;
    localparam logic [CW-1:0] LIM = CW'(MIN_WR - 1);

    wr_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          err_q, err_set;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_q | err_set;
        end
    end

    // next state and outputs
    always_comb begin
        wr_ok   = sel && (cnt_q == LIM);
        err_set = 1'b0;
        state_d = state_q;
        if (!sel)
            cnt_d = '0;
        else if (cnt_q == LIM)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (sel) state_d = wr_ok ? ST_OPEN : ST_ARM;
            end
            ST_ARM: begin
                if (!sel) begin
                    state_d = ST_IDLE;
                    err_set = 1'b1;
                end else if (wr_ok) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (!sel) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign short_err = err_q;
endmodule

// File: rtl/dac_regs.sv
module dac_regs #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_s,
    input  logic         wr_ok,
    input  logic         ld_act,
    output logic [W-1:0] in_q,
    output logic [W-1:0] dac_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            if (wr_ok) in_q <= bus_s;
            if (ld_act) dac_q <= wr_ok ? bus_s : in_q;
        end
    end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder #(
    parameter int W        = 14,
    parameter int MSB_BITS = 3,
    localparam int SEGS    = (1 << MSB_BITS) - 1,
    localparam int LSB     = W - MSB_BITS
) (
    input  logic [W-1:0]    code,
    output logic [SEGS-1:0] therm,
    output logic [LSB-1:0]  bin
);
    logic [MSB_BITS-1:0] top_bits;
    assign top_bits = code[W-1 -: MSB_BITS];
    assign bin      = code[LSB-1:0];

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        assign therm[g] = (top_bits > MSB_BITS'(g));
    end
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
    parameter int  W        = 14,
    parameter int  MSB_BITS = 3,
    parameter int  MIN_WR   = 4,
    localparam int SEGS     = (1 << MSB_BITS) - 1,
    localparam int LSB      = W - MSB_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic            ld_n,
    input  logic [W-1:0]    data_in,
    output logic [SEGS-1:0] therm_en,
    output logic [LSB-1:0]  ladder_en,
    output logic [W-1:0]    dac_code,
    output logic            short_err
);
    logic [2:0]   strb_s;
    logic         cs_s_n, wr_s_n, ld_s_n;
    logic [W-1:0] bus_s;
    logic [W-1:0] in_q;
    logic         wr_ok;

    dual_ff_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_strb_sync (
        .clk(clk), .rst(rst), .d({cs_n, wr_n, ld_n}), .q(strb_s)
    );

    dual_ff_sync #(.WIDTH(W), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst(rst), .d(data_in), .q(bus_s)
    );

    assign cs_s_n = strb_s[2];
    assign wr_s_n = strb_s[1];
    assign ld_s_n = strb_s[0];

    wr_qualifier #(.MIN_WR(MIN_WR)) u_qual (
        .clk(clk), .rst(rst), .sel(!cs_s_n && !wr_s_n),
        .wr_ok(wr_ok), .short_err(short_err)
    );

    dac_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .bus_s(bus_s), .wr_ok(wr_ok),
        .ld_act(!ld_s_n), .in_q(in_q), .dac_q(dac_code)
    );

    seg_decoder #(.W(W), .MSB_BITS(MSB_BITS)) u_dec (
        .code(dac_code), .therm(therm_en), .bin(ladder_en)
    );
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
    parameter int  W        = 14,
    parameter int  MSB_BITS = 3,
    localparam int SEGS     = (1 << MSB_BITS) - 1
) (
    input logic            clk,
    input logic            rst,
    input logic            ld_s_n,
    input logic            wr_ok,
    input logic [W-1:0]    bus_s,
    input logic [W-1:0]    in_q,
    input logic [W-1:0]    dac_code,
    input logic [SEGS-1:0] therm_en,
    input logic            short_err
);
    logic [SEGS:0] t_ext;
    assign t_ext = {1'b0, therm_en};

    AST_CAPTURE_KEEPS_DAC: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && ld_s_n) |=> $stable(dac_code)); // R2
    AST_CAPTURE_INPUT: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (in_q == $past(bus_s))); // R2
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (!ld_s_n && !wr_ok) |=> (dac_code == $past(in_q))); // R3
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (!ld_s_n && wr_ok) |=> (dac_code == $past(bus_s))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ld_s_n && !wr_ok) |=> $stable(dac_code)); // R5
    AST_THERM_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(therm_en) == int'(dac_code[W-1 -: MSB_BITS])); // R7
    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ((t_ext + 1'b1) & t_ext) == '0); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        short_err |=> short_err); // R9
endmodule

bind seg_dac_front seg_dac_front_chk #(.W(W), .MSB_BITS(MSB_BITS)) u_chk (
    .clk(clk), .rst(rst), .ld_s_n(ld_s_n), .wr_ok(wr_ok), .bus_s(bus_s),
    .in_q(in_q), .dac_code(dac_code), .therm_en(therm_en), .short_err(short_err)
);

// File: tb/seg_dac_front_bench.sv
module seg_dac_front_bench;
    localparam int W = 14;
    localparam int MIN_WR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [W-1:0] data_in = '0;
    logic [6:0] therm_en;
    logic [10:0] ladder_en;
    logic [W-1:0] dac_code;
    logic short_err;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_in = '0, exp_dac = '0;
    logic exp_err = 1'b0;

    always #5 clk = ~clk;

    seg_dac_front #(.W(W), .MSB_BITS(3), .MIN_WR(MIN_WR)) u_seg_dac_front (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
        .data_in(data_in), .therm_en(therm_en), .ladder_en(ladder_en),
        .dac_code(dac_code), .short_err(short_err)
    );

    function automatic logic [6:0] therm_of(input logic [W-1:0] c);
        logic [6:0] t = '0;
        for (int i = 0; i < 7; i++) t[i] = (int'(c[13:11]) > i);
        return t;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_strobes();
        cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " code"}, 32'(dac_code), 32'(exp_dac));
        chk({tag, " R7 therm"}, 32'(therm_en), 32'(therm_of(exp_dac)));
        chk({tag, " R8 ladder"}, 32'(ladder_en), 32'(exp_dac[10:0]));
        chk({tag, " R9 err"}, 32'(short_err), 32'(exp_err));
    endtask

    task automatic op_write(input logic [W-1:0] d, input int h);
        cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b1; data_in = d;
        step(h);
        idle_strobes(); data_in = ~d;
        step(4);
        if (h >= MIN_WR) exp_in = d; else exp_err = 1'b1;
    endtask

    task automatic op_load();
        ld_n = 1'b0; step(2);
        idle_strobes(); step(4);
        exp_dac = exp_in;
    endtask

    task automatic op_trans(input logic [W-1:0] d, input int h);
        cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0; data_in = d;
        step(h);
        idle_strobes(); data_in = ~d;
        step(4);
        exp_in = d; exp_dac = d;
    endtask

    task automatic op_noop(input logic [W-1:0] d);
        cs_n = 1'b1; wr_n = 1'b0; ld_n = 1'b1; data_in = d;
        step(3);
        cs_n = 1'b0; wr_n = 1'b1; data_in = ~d;
        step(3);
        idle_strobes(); step(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        step(5);
        rst = 1'b0;
        step(1);
        check_all("R1 reset");

        // R2: capture at exactly MIN_WR, DAC untouched
        op_write(14'h2ABC, MIN_WR);
        check_all("R2 capture keeps dac");
        op_load();
        check_all("R3 load copies");

        // R10: latency of load strobe
        op_write(14'h1357, MIN_WR);
        ld_n = 1'b0;
        step(2);
        chk("R10 before third edge", 32'(dac_code), 32'(exp_dac));
        step(1);
        chk("R10 at third edge", 32'(dac_code), 32'(14'h1357));
        idle_strobes(); step(4);
        exp_dac = exp_in;
        check_all("R10 settled");

        // R5: deselected activity ignored
        op_noop(14'h3FFF);
        check_all("R5 noop");
        op_load();
        check_all("R5 input kept");

        // R9: short write ignored, sticky flag
        op_write(14'h0F0F, MIN_WR - 1);
        check_all("R9 short write");
        op_load();
        check_all("R9 input kept after short");

        // R4: transparent over all thermometer codes
        for (int k = 0; k < 8; k++) begin
            op_trans({k[2:0], 11'h5A5}, MIN_WR + 1);
            check_all("R4 R7 transparent");
        end

        // R6: write released while load stays low, new word on the bus
        cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0; data_in = 14'h0AAA;
        step(MIN_WR + 1);
        data_in = 14'h3555;
        step(2);
        wr_n = 1'b1; data_in = 14'h1111;
        step(4);
        idle_strobes(); step(4);
        exp_in = 14'h3555; exp_dac = 14'h3555;
        check_all("R6 trailing load");

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] d = W'($urandom);
            int sel = int'($urandom % 4);
            case (sel)
                0: op_write(d, MIN_WR + int'($urandom % 4));
                1: op_load();
                2: op_trans(d, MIN_WR + int'($urandom % 4));
                default: op_noop(d);
            endcase
            check_all("R2 R3 R4 R5 random");
        end

        rst = 1'b1; step(2); rst = 1'b0; step(1);
        exp_in = '0; exp_dac = '0; exp_err = 1'b0;
        check_all("R1 second reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule